// File: doc/BRIEF.md
# Bit-Selected-Reset PWM Timer

This block produces one pulse-width-modulated output from an 8-bit up-counter that steps once per tick-enable pulse. The tick is meant to arrive at 32 kHz, though the block only counts pulses. There is no period compare register. The period comes from a 2-bit prescaler field that chooses which counter bit clears the counter once it would become set. Lower prescaler values therefore give longer periods with more resolution, and higher values give shorter periods with fewer live count bits.

A 7-bit duty value sets the high time in ticks. Each tick the duty value is compared against the live count bits. Software sets the mode and the duty through two byte-wide registers reached over a simple synchronous port that has separate read and write strobes.

Writes take effect at once. Duty and prescaler are not shadowed, and a prescaler change does not clear the counter. Software must therefore order its writes when it moves between periods.

Top module: `bitsel_pwm_top`

## Requirements
- R1: A synchronous active-high reset clears the control register, the duty register, the counter and the read data. While reset holds and after it, with nothing written, the output is low.
- R2: The register at offset 0x00 holds the run bit in bit 7 and the prescaler p in bits 1:0. The register at offset 0x01 holds the duty in bits 6:0. Control bits 6:2 and duty bit 7 read as zero and ignore writes. Reads and writes at any other offset return zero and change nothing. Read data appears the cycle after the read strobe is sampled.
- R3: While running, the counter advances only on cycles with the tick enable high and holds otherwise. While stopped, the counter is held at zero.
- R4: On a tick, if the incremented counter has bit (7-p) set, the counter loads zero instead. The period is therefore 128>>p ticks: 128, 64, 32 and 16 for p = 0 to 3.
- R5: While running, the output is high exactly when the live bits (6-p):0 of the counter are strictly below the duty value. A duty of 0 keeps the output low.
- R6: A duty of 1<<(7-p) or more keeps the output high for the whole period. With p = 0 the largest storable duty, 127, still leaves one low tick per 128.
- R7: A new duty value is used from the cycle after the write. It does not wait for the end of the period.
- R8: A prescaler change leaves the counter as it is. The counter keeps stepping until the incremented value sets the new reset bit, and only the new live bits are compared.
- R9: While stopped, the output is low. Setting the run bit starts the count from zero, so the first period begins with its high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | Counter step enable, one pulse per tick |
| reg_addr | input | 8 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 8 | Read data, registered |
| pwm_out | output | 1 | PWM output |

## Verification
The assertions assume that no read and no write is issued while reset is high, and that the strobes and address are steady across each clock edge. The bench drives every input half a cycle away from the sampling edge and keeps all register traffic out of the reset window. The properties also assume that the counter can only be outside the live range just after a prescaler change. The stimulus reaches that state only through real prescaler writes, and never forces the counter.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    parameter int CNT_W  = 8;
    parameter int DATA_W = 8;
    parameter int ADDR_W = 8;
    parameter int PSEL_W = 2;

    localparam int DUTY_W = CNT_W - 1;
    localparam int NSEL   = 1 << PSEL_W;

    localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] OFS_DUTY = ADDR_W'(1);

    localparam int RUN_BIT = DATA_W - 1;

    typedef struct packed {
        logic              run;
        logic [PSEL_W-1:0] psel;
    } mode_t;

    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [DUTY_W-1:0] duty_t;

    // Mask of the count bits that are compared for a given prescaler.
    function automatic cnt_t live_mask(input logic [PSEL_W-1:0] p);
        cnt_t one;
        one = CNT_W'(1);
        return (one << (CNT_W - 1 - int'(p))) - one;
    endfunction

    // Pack the mode into the register image; unused bits are zero.
    function automatic logic [DATA_W-1:0] mode_image(input mode_t m);
        logic [DATA_W-1:0] r;
        r = '0;
        r[RUN_BIT] = m.run;
        r[PSEL_W-1:0] = m.psel;
        return r;
    endfunction

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr,
    input  logic              rd,
    output logic [DATA_W-1:0] rdata,
    output mode_t             mode,
    output duty_t             duty
);

    logic [DATA_W-1:0] rd_mux;
    logic              hit_ctrl;
    logic              hit_duty;

    assign hit_ctrl = (addr == OFS_CTRL);
    assign hit_duty = (addr == OFS_DUTY);

    always_comb begin
        rd_mux = '0;
        if (hit_ctrl) begin
            rd_mux = mode_image(mode);
        end else if (hit_duty) begin
            rd_mux[DUTY_W-1:0] = duty;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode  <= '0;
            duty  <= '0;
            rdata <= '0;
        end else begin
            if (wr && hit_ctrl) begin
                mode.run  <= wdata[RUN_BIT];
                mode.psel <= wdata[PSEL_W-1:0];
            end
            if (wr && hit_duty) begin
                duty <= wdata[DUTY_W-1:0];
            end
            if (rd) begin
                rdata <= rd_mux;
            end
        end
    end

endmodule

// File: rtl/pwm_counter.sv
module pwm_counter
    import pwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              tick,
    input  logic [PSEL_W-1:0] psel,
    output cnt_t              cnt
);

    cnt_t            cnt_inc;
    logic [NSEL-1:0] wrap_by_sel;
    logic            wrap;

    assign cnt_inc = cnt + CNT_W'(1);

    // One candidate reset bit per prescaler setting.
    for (genvar i = 0; i < NSEL; i++) begin : g_wrap
        assign wrap_by_sel[i] = cnt_inc[CNT_W-1-i];
    end

    assign wrap = wrap_by_sel[psel];

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= wrap ? '0 : cnt_inc;
        end
    end

endmodule

// File: rtl/pwm_compare.sv
module pwm_compare
    import pwm_pkg::*;
(
    input  logic              run,
    input  logic [PSEL_W-1:0] psel,
    input  cnt_t              cnt,
    input  duty_t             duty,
    output logic              pwm
);

    cnt_t live;

    assign live = cnt & live_mask(psel);
    assign pwm  = run && (live < {1'b0, duty});

endmodule

// File: rtl/bitsel_pwm_top.sv
module bitsel_pwm_top
    import pwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_wr,
    input  logic              reg_rd,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              pwm_out
);

    mode_t             mode_q;
    duty_t             duty_q;
    cnt_t              cnt_q;
    logic              run_w;
    logic [PSEL_W-1:0] psel_w;

    assign run_w  = mode_q.run;
    assign psel_w = mode_q.psel;

    pwm_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .wr    (reg_wr),
        .rd    (reg_rd),
        .rdata (reg_rdata),
        .mode  (mode_q),
        .duty  (duty_q)
    );

    pwm_counter u_cnt (
        .clk  (clk),
        .rst  (rst),
        .run  (run_w),
        .tick (tick_en),
        .psel (psel_w),
        .cnt  (cnt_q)
    );

    pwm_compare u_cmp (
        .run  (run_w),
        .psel (psel_w),
        .cnt  (cnt_q),
        .duty (duty_q),
        .pwm  (pwm_out)
    );

endmodule

// File: rtl/pwm_checker.sv
module pwm_checker
    import pwm_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              tick_en,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_rd,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              pwm_out,
    input logic              run,
    input logic [PSEL_W-1:0] psel,
    input cnt_t              cnt,
    input duty_t             duty
);

    // R1: reset leaves counter, output and read data at zero
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (cnt == '0) && (reg_rdata == '0) && !pwm_out);

    // R2: duty readback never shows bit 7
    a_r2_duty_msb_zero: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == OFS_DUTY) |=> !reg_rdata[DATA_W-1]);

    // R3: no tick while running leaves the count unchanged
    a_r3_hold_no_tick: assert property (@(posedge clk) disable iff (rst)
        (run && !tick_en) |=> $stable(cnt));

    // R3: stopped means the counter is zero on the next cycle
    a_r3_stopped_zero: assert property (@(posedge clk) disable iff (rst)
        !run |=> (cnt == '0));

    // R5: zero duty never drives the output high
    a_r5_zero_duty_low: assert property (@(posedge clk) disable iff (rst)
        (duty == '0) |-> !pwm_out);

    // R6: full-scale duty holds the output high
    a_r6_full_high: assert property (@(posedge clk) disable iff (rst)
        (run && ({1'b0, duty} >= (CNT_W'(1) << (CNT_W - 1 - int'(psel))))) |-> pwm_out);

    // R9: stopped output is low
    a_r9_stopped_low: assert property (@(posedge clk) disable iff (rst)
        !run |-> !pwm_out);

endmodule

bind bitsel_pwm_top pwm_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick_en   (tick_en),
    .reg_addr  (reg_addr),
    .reg_rd    (reg_rd),
    .reg_rdata (reg_rdata),
    .pwm_out   (pwm_out),
    .run       (run_w),
    .psel      (psel_w),
    .cnt       (cnt_q),
    .duty      (duty_q)
);

// File: tb/sim_bitsel_pwm_top.sv
`timescale 1ns/1ps
module sim_bitsel_pwm_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b0;
    logic [7:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_rdata;
    logic       pwm_out;

    int total = 0;
    int bad = 0;

    // bench model, written from the requirements
    logic [7:0] m_cnt = '0;
    logic       m_run = 1'b0;
    logic [1:0] m_p = '0;
    logic [6:0] m_duty = '0;

    always #2.5 clk = ~clk;

    bitsel_pwm_top u0 (
        .clk       (clk),
        .rst       (rst),
        .tick_en   (tick_en),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_rdata (reg_rdata),
        .pwm_out   (pwm_out)
    );

    typedef struct packed {
        logic [1:0] p;
        logic [6:0] duty;
        logic [7:0] ncyc;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{p: 2'd0, duty: 7'd40,  ncyc: 8'd200},
        '{p: 2'd1, duty: 7'd10,  ncyc: 8'd150},
        '{p: 2'd2, duty: 7'd31,  ncyc: 8'd100},
        '{p: 2'd3, duty: 7'd3,   ncyc: 8'd60},
        '{p: 2'd3, duty: 7'd15,  ncyc: 8'd40},
        '{p: 2'd2, duty: 7'd0,   ncyc: 8'd70},
        '{p: 2'd1, duty: 7'd63,  ncyc: 8'd140},
        '{p: 2'd0, duty: 7'd1,   ncyc: 8'd255}
    };

    task automatic model_adv();
        logic [7:0] n;
        if (rst) begin
            m_cnt = '0; m_run = 1'b0; m_p = '0; m_duty = '0;
        end else begin
            if (!m_run) begin
                m_cnt = '0;
            end else if (tick_en) begin
                n = m_cnt + 8'd1;
                m_cnt = n[7 - m_p] ? 8'd0 : n;
            end
            if (reg_wr && reg_addr == 8'h00) begin
                m_run = reg_wdata[7];
                m_p = reg_wdata[1:0];
            end
            if (reg_wr && reg_addr == 8'h01) m_duty = reg_wdata[6:0];
        end
    endtask

    function automatic logic model_out();
        logic [7:0] live;
        live = m_cnt & ((8'd1 << (7 - m_p)) - 8'd1);
        return m_run && (live < {1'b0, m_duty});
    endfunction

    task automatic cycle(input logic t);
        tick_en = t;
        @(posedge clk);
        model_adv();
        @(negedge clk);
        reg_wr = 1'b0;
        reg_rd = 1'b0;
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_model(input string req);
        check(req, {7'd0, pwm_out}, {7'd0, model_out()});
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        cycle(1'b1);
    endtask

    task automatic rd_check(input string req, input logic [7:0] a, input logic [7:0] exp);
        reg_addr = a; reg_rd = 1'b1;
        cycle(1'b1);
        check(req, reg_rdata, exp);
    endtask

    task automatic restart(input logic [1:0] p);
        wr(8'h00, 8'h00);
        wr(8'h00, {1'b1, 5'd0, p});
    endtask

    initial begin
        #600000;
        total++;
        bad++;
        $display("FAIL watchdog expired, run incomplete");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int k;
        int lows;
        logic seen_low;
        @(negedge clk);
        repeat (3) cycle(1'b1);
        check("R1 output in reset", {7'd0, pwm_out}, 8'd0);
        rst = 1'b0;
        cycle(1'b1);
        check("R1 output after reset", {7'd0, pwm_out}, 8'd0);
        rd_check("R1 ctrl after reset", 8'h00, 8'h00);
        rd_check("R1 duty after reset", 8'h01, 8'h00);

        // R2 register map and masking
        wr(8'h01, 8'hFF);
        rd_check("R2 duty bit7 masked", 8'h01, 8'h7F);
        wr(8'h00, 8'h7C);
        rd_check("R2 ctrl 6:2 masked", 8'h00, 8'h00);
        wr(8'h05, 8'hFF);
        rd_check("R2 stray write no effect ctrl", 8'h00, 8'h00);
        rd_check("R2 stray write no effect duty", 8'h01, 8'h7F);
        rd_check("R2 stray offset reads zero", 8'h05, 8'h00);
        wr(8'h00, 8'h83);
        rd_check("R2 ctrl readback", 8'h00, 8'h83);

        // table walk: R5 compare, R7 duty change mid-period, R8 prescaler switch
        wr(8'h00, 8'h00);
        for (int v = 0; v < NVEC; v++) begin
            wr(8'h00, {1'b1, 5'd0, VECS[v].p});
            check_model("R8 after prescaler write");
            wr(8'h01, {1'b0, VECS[v].duty});
            check_model("R7 after duty write");
            for (int c = 0; c < int'(VECS[v].ncyc); c++) begin
                cycle(1'b1);
                check_model("R5 table compare");
            end
        end

        // R3 hold without tick
        restart(2'd1);
        wr(8'h01, 8'd5);
        repeat (3) cycle(1'b1);
        for (int c = 0; c < 10; c++) begin
            cycle(1'b0);
            check_model("R3 no tick hold");
        end
        repeat (4) begin
            cycle(1'b1);
            check_model("R3 resume counting");
        end

        // R4 period per prescaler, duty 1
        for (int p = 0; p < 4; p++) begin
            restart(2'(p));
            wr(8'h01, 8'd1);
            restart(2'(p));
            check("R9 high at start", {7'd0, pwm_out}, 8'd1);
            k = 0; seen_low = 1'b0;
            for (int c = 0; c < 300; c++) begin
                cycle(1'b1);
                k++;
                if (!pwm_out) seen_low = 1'b1;
                else if (seen_low) break;
            end
            check("R4 period ticks", 8'(k), 8'(128 >> p));
        end

        // R6 full scale
        restart(2'd1);
        wr(8'h01, 8'd64);
        lows = 0;
        for (int c = 0; c < 200; c++) begin
            cycle(1'b1);
            if (!pwm_out) lows++;
        end
        check("R6 full duty p1 always high", 8'(lows), 8'd0);
        restart(2'd0);
        wr(8'h01, 8'd127);
        lows = 0;
        for (int c = 0; c < 128; c++) begin
            cycle(1'b1);
            if (!pwm_out) lows++;
        end
        check("R6 p0 duty 127 one low tick", 8'(lows), 8'd1);

        // R5 zero duty
        wr(8'h01, 8'd0);
        lows = 0;
        for (int c = 0; c < 100; c++) begin
            cycle(1'b1);
            if (!pwm_out) lows++;
        end
        check("R5 zero duty low", 8'(lows), 8'd100);

        // R8 explicit: counter beyond new range after switch
        restart(2'd0);
        wr(8'h01, 8'd5);
        repeat (98) cycle(1'b1);
        wr(8'h00, 8'h83);
        for (int c = 0; c < 40; c++) begin
            check_model("R8 switch without clear");
            cycle(1'b1);
        end

        // R9 stop and restart
        wr(8'h01, 8'd20);
        wr(8'h00, 8'h01);
        for (int c = 0; c < 20; c++) begin
            cycle(1'b1);
            check("R9 stopped low", {7'd0, pwm_out}, 8'd0);
        end
        wr(8'h00, 8'h81);
        check("R9 restart high", {7'd0, pwm_out}, 8'd1);
        for (int c = 0; c < 70; c++) begin
            cycle(1'b1);
            check_model("R9 restart sequence");
        end

        // R1 reset in mid-run
        rst = 1'b1;
        cycle(1'b1);
        rst = 1'b0;
        check("R1 output after late reset", {7'd0, pwm_out}, 8'd0);
        rd_check("R1 ctrl after late reset", 8'h00, 8'h00);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule